// File: doc/BRIEF.md
# Filtered-PWM Successive Approximation Converter

This block builds a slow analog-to-digital converter out of a PWM output, an external RC low-pass filter and an external analog comparator. The PWM duty code acts as the reference voltage: after the filter averages the waveform, the comparator says whether that level sits above the unknown input. The controller runs a bisection over the duty code. It keeps a lower and an upper bound and moves one of them to the current trial on each comparison.

Each trial proceeds in a fixed order. The new duty code is applied on a PWM period boundary, so the output never carries a short glitch pulse. The controller then waits a long settling interval so the filter output can follow. A short pseudo-random extra wait comes next, so that the sampling instant does not lock onto the ripple of the filtered waveform. Only then is the comparator sampled. After eight trials the remaining trial code is the result, and a one-cycle strobe marks it.

Both the settling interval and the dither unit are given in clock cycles. Their defaults suit a 15 ms settle at 16 MHz, and a test setup can shrink them.

Top module: `pwmdac_sar`

## Requirements
- R1: After reset `busy` and `resultValid` are low and `pwmOut` is low, because the duty code resets to 0.
- R2: A `startPulse` while idle raises `busy` on the next clock edge and begins a conversion with trial code 127, lower bound 0 and upper bound 255.
- R3: The PWM period is 256 clocks. In each period `pwmOut` is high for exactly as many clocks as the current duty code. A new duty code takes effect only at a period boundary, and when idle the duty code equals the last result.
- R4: `cmpIn` passes through two synchronizing flops. A sampled 1 means the filtered level is above the input and moves the upper bound to the trial code. A sampled 0 moves the lower bound to the trial code.
- R5: After each comparison the next trial code is lower bound + ((upper bound − lower bound) >> 1), computed with the updated bounds.
- R6: Before each comparator sample the controller waits at least `SETTLE_CYC` clocks, counted from the period boundary at which the trial duty was loaded.
- R7: After the settling wait an extra delay of k × `DITHER_UNIT` clocks is added. Here k (0 to 31) is the low five bits of a free-running maximal-length 8-bit LFSR, captured at the start of each trial.
- R8: A conversion has exactly eight trials. `resultCode` is the trial code after the eighth update and is valid while `resultValid` is high. `resultValid` is high for exactly one cycle, and `busy` is low on the cycle after it.
- R9: A `startPulse` while `busy` is high is ignored: the conversion neither restarts nor changes its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin a conversion |
| cmpIn | input | 1 | Raw comparator output, 1 when the filtered PWM level is above the input |
| pwmOut | output | 1 | PWM waveform that drives the RC filter |
| busy | output | 1 | High while a conversion is in progress |
| resultValid | output | 1 | One-cycle strobe marking `resultCode` as valid |
| resultCode | output | 8 | Converted code |

## Verification
A wrong bound or trial update does not stay inside the block. It sends the bisection down another branch, so the code reported at the end of that conversion differs from the one predicted by replaying the search against the measured duty. The idle PWM duty then differs as well, one period later. A wrong duty load instant or wrong waveform shape shows up within one PWM period as a high-time count that does not match the code. A wrong settle, dither or trial count moves the time from start to strobe outside the window implied by the parameters, and a restart caused by a late start request pushes it past the upper end of that window.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  typedef struct packed {
    logic init;
    logic step;
  } sarStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_SETTLE, ST_DITHER, ST_DECIDE, ST_DONE
  } sarState_t;
endpackage

// File: rtl/pwmdac_datapath.sv
module pwmdac_datapath
  import pwmdac_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strb,
  input  logic              cmpIn,
  output logic              pwmOut,
  output logic              periodEnd,
  output logic [CODE_W-1:0] trialCode
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_MAX >> 1;

  logic [CODE_W-1:0] pwmCnt, dutyReg, loBound, hiBound;
  logic [CODE_W-1:0] newLo, newHi;
  logic [1:0]        cmpSync;

  assign periodEnd = (pwmCnt == CODE_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt  <= '0;
      dutyReg <= '0;
      pwmOut  <= 1'b0;
      cmpSync <= '0;
    end else begin
      pwmCnt  <= pwmCnt + 1'b1;
      cmpSync <= {cmpSync[0], cmpIn};
      pwmOut  <= (pwmCnt < dutyReg);
      if (periodEnd) dutyReg <= trialCode;
    end
  end

  always_comb begin
    newLo = loBound;
    newHi = hiBound;
    if (cmpSync[1]) newHi = trialCode;
    else            newLo = trialCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      loBound   <= '0;
      hiBound   <= CODE_MAX;
    end else if (strb.init) begin
      trialCode <= CODE_MID;
      loBound   <= '0;
      hiBound   <= CODE_MAX;
    end else if (strb.step) begin
      loBound   <= newLo;
      hiBound   <= newHi;
      trialCode <= newLo + ((newHi - newLo) >> 1);
    end
  end

  // R3
  duty_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dutyReg) |-> pwmCnt == '0);
  // R5
  bounds_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.step) |-> (loBound <= trialCode) && (trialCode <= hiBound));
  // R2
  init_values_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.init |=> trialCode == CODE_MID && loBound == '0 && hiBound == CODE_MAX);
endmodule

// File: rtl/pwmdac_control.sv
module pwmdac_control
  import pwmdac_pkg::*;
#(
  parameter int TRIALS      = 8,
  parameter int SETTLE_CYC  = 240000,
  parameter int DITHER_UNIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       periodEnd,
  output sarStrobe_t strb,
  output logic       busy,
  output logic       resultValid
);
  localparam int DITHER_W  = 5;
  localparam int DITH_MAX  = ((1 << DITHER_W) - 1) * DITHER_UNIT;
  localparam int WAIT_TOP  = (SETTLE_CYC > DITH_MAX) ? SETTLE_CYC : DITH_MAX;
  localparam int CNT_W     = $clog2(WAIT_TOP + 2);
  localparam int ITER_W    = $clog2(TRIALS + 1);

  sarState_t           state;
  logic [CNT_W-1:0]    waitCnt;
  logic [CNT_W-1:0]    ditherTarget;
  logic [ITER_W-1:0]   iterCnt;
  logic [7:0]          lfsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= 8'h01;
    else       lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_comb begin
    strb.init = (state == ST_IDLE) && startPulse;
    strb.step = (state == ST_DECIDE);
  end

  assign busy        = (state != ST_IDLE);
  assign resultValid = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      waitCnt      <= '0;
      ditherTarget <= '0;
      iterCnt      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse) begin
          iterCnt <= '0;
          state   <= ST_ALIGN;
        end
        ST_ALIGN: if (periodEnd) begin
          waitCnt      <= '0;
          ditherTarget <= CNT_W'(int'(lfsr[DITHER_W-1:0]) * DITHER_UNIT);
          state        <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (waitCnt == CNT_W'(SETTLE_CYC - 1)) begin
            waitCnt <= '0;
            state   <= ST_DITHER;
          end else waitCnt <= waitCnt + 1'b1;
        end
        ST_DITHER: begin
          if (waitCnt >= ditherTarget) state <= ST_DECIDE;
          else                         waitCnt <= waitCnt + 1'b1;
        end
        ST_DECIDE: begin
          if (iterCnt == ITER_W'(TRIALS - 1)) state <= ST_DONE;
          else begin
            iterCnt <= iterCnt + 1'b1;
            state   <= ST_ALIGN;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid && !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !resultValid && startPulse) |=> busy && !strb.init);
  // R7
  dither_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DITHER) |-> ditherTarget <= CNT_W'(DITH_MAX));
  // R6
  settle_before_decide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE) |-> $past(state) == ST_DITHER);
  // R8
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> iterCnt < ITER_W'(TRIALS));
endmodule

// File: rtl/pwmdac_sar.sv
module pwmdac_sar
  import pwmdac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SETTLE_CYC  = 240000,
  parameter int DITHER_UNIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              cmpIn,
  output logic              pwmOut,
  output logic              busy,
  output logic              resultValid,
  output logic [CODE_W-1:0] resultCode
);
  sarStrobe_t strb;
  logic       periodEnd;

  pwmdac_control #(
    .TRIALS(CODE_W), .SETTLE_CYC(SETTLE_CYC), .DITHER_UNIT(DITHER_UNIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .periodEnd(periodEnd),
    .strb(strb), .busy(busy), .resultValid(resultValid)
  );

  pwmdac_datapath #(.CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpIn(cmpIn),
    .pwmOut(pwmOut), .periodEnd(periodEnd), .trialCode(resultCode)
  );
endmodule

// File: tb/pwmdac_sar_test.sv
module pwmdac_sar_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 600;
  localparam int UNIT       = 2;
  localparam int MIN_CONV   = 8 * (SETTLE + 3);
  localparam int MAX_CONV   = 8 * (SETTLE + 258 + 31 * UNIT) + 4;

  logic clk = 0, rstN = 0, startPulse = 0, cmpIn = 0;
  logic pwmOut, busy, resultValid;
  logic [7:0] resultCode;
  logic [255:0] hist = '0;
  int vin = 0;
  int checks = 0, failures = 0;

  pwmdac_sar #(.CODE_W(8), .SETTLE_CYC(SETTLE), .DITHER_UNIT(UNIT)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpIn(cmpIn),
    .pwmOut(pwmOut), .busy(busy), .resultValid(resultValid), .resultCode(resultCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Filter + comparator model: average over the last 256 samples.
  always @(negedge clk) begin
    hist  <= {hist[254:0], pwmOut};
    cmpIn <= ($countones(hist) > vin);
  end

  function automatic int expectCode(int v);
    int t = 127, lo = 0, hi = 255;
    for (int i = 0; i < 8; i++) begin
      if (t > v) hi = t; else lo = t;
      t = lo + ((hi - lo) >> 1);
    end
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(int v, bit poke);
    int cyc = 0;
    int res;
    vin = v;
    repeat (300) @(negedge clk);
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    check(busy == 1, "R2 busy after start", busy, 1);
    while (!resultValid && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3000) begin
        startPulse = 1;
        @(negedge clk);
        startPulse = 0;
        cyc++;
        check(busy == 1, "R9 busy kept", busy, 1);
      end
    end
    res = resultCode;
    check(res == expectCode(v), poke ? "R9 result" : "R4 R5 R8 result",
          res, expectCode(v));
    check(cyc >= MIN_CONV && cyc <= MAX_CONV, "R6 R7 R8 conversion time",
          cyc, MAX_CONV);
    @(negedge clk);
    check(resultValid == 0 && busy == 0, "R8 strobe one cycle", resultValid, 0);
    repeat (600) @(negedge clk);
    check($countones(hist) == res, "R3 idle duty", $countones(hist), res);
    check(busy == 0, "R8 idle after", busy, 0);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && resultValid == 0 && pwmOut == 0, "R1 reset", busy, 0);
    rstN = 1;
    repeat (300) @(negedge clk);
    check(pwmOut == 0 && busy == 0, "R1 idle after reset", pwmOut, 0);
    convert(0, 0);
    convert(255, 0);
    convert(127, 0);
    convert(128, 0);
    convert(1, 0);
    convert(200, 1);
    for (int i = 0; i < 7; i++) convert(int'($urandom_range(0, 255)), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule